// File: doc/BRIEF.md
# Link-to-PHY Power State Sequencer

This block sits between a link training state machine and a PIPE PHY. It turns requests to enter or leave the link low-power states (U1, U2, U3) into a sequence of PowerDown codes (P0 to P3). It moves the PHY one step at a time and waits for a PhyStatus pulse after each step. When the sequence reaches the point the link asked for, it answers with a one-cycle `done` pulse and updates the reported link state.

Entry into a low-power state can be held back while the receive lane is still busy. The release comes either when the lane goes electrically idle, or when a programmed number of 8b/10b decode errors has been seen or RxValid drops. An exit that arrives while the entry is still held can either cancel the entry or force it out first. A PHY that cannot switch directly between P2 and P3 is taken through P0. The exit handshake can run in P0, in the current low-power state, or in P2 when leaving U3.

A control word carries the options. It is captured whenever the sequencer is idle and then held for the whole transition.

Top module: `pipe_pwr_seq`

## Requirements
- R1: After reset, `power_down` is 0 (P0), `link_state` is 0 (U0) and `done` is low. Link state codes are 0..3 for U0..U3, and PowerDown codes are 0..3 for P0..P3.
- R2: An entry request is `link_req` 1..3 while `link_state` is 0. U1 targets P1 and U3 targets P3. U2 targets P2, or P3 when `ctl[0]` is 1. When the target is acknowledged, `done` pulses once and `link_state` becomes the requested code.
- R3: A step between P2 and P3 in either direction is made directly only when `ctl[1]` is 1. Otherwise P0 is requested in between.
- R4: `power_down` never changes while an earlier change has not yet been acknowledged by a `phy_status` pulse.
- R5: With `ctl[2]` set and `ctl[8:6]` zero, the entry request is held until `rx_elec_idle` is 1 and `rx_valid` is 0. With `ctl[2]` clear, it is issued at once.
- R6: With `ctl[2]` set and N = `ctl[8:6]` not zero, the entry request is held until 8×N `dec_err` pulses have been counted during the hold, or `rx_valid` is 0, whichever happens first.
- R7: A U0 request during the hold with `ctl[3]` clear cancels the entry. No PowerDown change is made, `done` pulses and `link_state` stays U0. The cancel takes precedence over a release that falls in the same cycle.
- R8: A U0 request during the hold with `ctl[3]` set issues the low-power request at once. When it is acknowledged, the exit sequence follows, and a single `done` is given with `link_state` U0.
- R9: An exit request is `link_req` 0 while `link_state` is not 0. With `ctl[4]` and `ctl[5]` clear, the PHY is brought to P0 before `done` pulses and `link_state` becomes U0.
- R10: With `ctl[4]` set, `done` for an exit pulses while the PHY is still in its low-power state. Afterwards the block returns the PHY to P0.
- R11: On a U3 exit with `ctl[5]` set, the PHY is moved to P2 before `done` pulses, and then returned to P0. This takes precedence over `ctl[4]`.
- R12: `ctl` is sampled only while no transition is in progress. Changing it mid-transition does not alter that transition.
- R13: Requests that are neither a legal entry nor a legal exit are ignored, as are requests during a transition (apart from the exit in R7 and R8). They change neither the outputs nor the link state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_req_vld | input | 1 | One-cycle strobe qualifying `link_req` |
| link_req | input | 2 | Requested link state, 0..3 = U0..U3 |
| ctl | input | 6+ERR_FLD_W | Option word: [0] U2 uses P3, [1] direct P2/P3, [2] hold entry, [3] always request, [4] exit in low-power state, [5] U3 exit through P2, [8:6] error units |
| rx_elec_idle | input | 1 | Receiver electrical idle from the PHY |
| rx_valid | input | 1 | Receive data valid from the PHY |
| dec_err | input | 1 | One pulse for each 8b/10b decode error |
| phy_status | input | 1 | PHY acknowledge pulse for a PowerDown change |
| power_down | output | 2 | PowerDown code driven to the PHY |
| link_state | output | 2 | Link state as reported to the link state machine |
| done | output | 1 | One-cycle pulse when a requested transition is complete |

## Verification
Two functions can land in the same cycle. One is the release of a held entry, here by the decode-error count reaching its threshold. The other is the arrival of an exit request. The bench feeds exactly 8×N error pulses and places the U0 request on the first edge where the count is complete. It then expects the cancel path: no PowerDown change, one `done`, link state U0. A second overlap is a stray request or a new control word arriving while a sequence is under way. Each random transaction does this on its second cycle, and the bench compares the PowerDown steps it observes against a path computed from the control word that was in force when the request was accepted.

// File: rtl/pipe_pwr_seq.sv
module pipe_pwr_seq #(
  parameter int ERR_UNIT  = 8,
  parameter int ERR_FLD_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_req_vld,
  input  logic [1:0]           link_req,
  input  logic [5+ERR_FLD_W:0] ctl,
  input  logic                 rx_elec_idle,
  input  logic                 rx_valid,
  input  logic                 dec_err,
  input  logic                 phy_status,
  output logic [1:0]           power_down,
  output logic [1:0]           link_state,
  output logic                 done
);
  localparam int CTL_W = 6 + ERR_FLD_W;
  localparam int ERR_MAX_I = ERR_UNIT * ((1 << ERR_FLD_W) - 1);
  localparam int CNT_W = $clog2(ERR_MAX_I + 1);
  localparam logic [CNT_W-1:0] ERR_MAX = CNT_W'(ERR_MAX_I);
  localparam logic [CNT_W-1:0] UNIT_C  = CNT_W'(ERR_UNIT);
  localparam logic [1:0] P0 = 2'd0, P1 = 2'd1, P2 = 2'd2, P3 = 2'd3;
  localparam logic [1:0] U0 = 2'd0;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_BUSY} st_t;
  typedef enum logic [1:0] {PH_ENTRY, PH_EXIT, PH_TAIL} ph_t;

  st_t              st;
  ph_t              phase;
  logic [CTL_W-1:0] cfg_q;
  logic [1:0]       goal, tgt;
  logic             waiting, pend_exit;
  logic [CNT_W-1:0] errc;

  wire [CTL_W-1:0]     cfg    = (st == S_IDLE) ? ctl : cfg_q;
  wire [ERR_FLD_W-1:0] units  = cfg[6 +: ERR_FLD_W];
  wire [CNT_W-1:0]     thr    = UNIT_C * CNT_W'(units);
  wire                 rel    = (units == '0) ? (rx_elec_idle && !rx_valid)
                                              : (!rx_valid || errc >= thr);
  wire                 exit_q = link_req_vld && link_req == U0;

  function automatic logic [1:0] entry_goal(input logic [1:0] u, input logic u2p3);
    case (u)
      2'd1:    return P1;
      2'd2:    return u2p3 ? P3 : P2;
      default: return P3;
    endcase
  endfunction

  function automatic logic [1:0] exit_goal(input logic [1:0] u, input logic [1:0] cur,
                                           input logic in_px, input logic u3p2);
    if (u == 2'd3 && u3p2) return P2;
    if (in_px)             return cur;
    return P0;
  endfunction

  function automatic logic [1:0] next_hop(input logic [1:0] cur, input logic [1:0] g,
                                          input logic direct);
    if (((cur == P2 && g == P3) || (cur == P3 && g == P2)) && !direct) return P0;
    return g;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  phase <= PH_ENTRY;  cfg_q <= '0;
      goal <= P0;  tgt <= U0;  waiting <= 1'b0;  pend_exit <= 1'b0;
      errc <= '0;  power_down <= P0;  link_state <= U0;  done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) cfg_q <= ctl;
      case (st)
        S_IDLE: if (link_req_vld) begin
          if (link_state == U0 && link_req != U0) begin
            tgt <= link_req;
            goal <= entry_goal(link_req, cfg[0]);
            phase <= PH_ENTRY;
            pend_exit <= 1'b0;
            errc <= '0;
            st <= cfg[2] ? S_HOLD : S_BUSY;
          end else if (link_state != U0 && link_req == U0) begin
            goal <= exit_goal(link_state, power_down, cfg[4], cfg[5]);
            phase <= PH_EXIT;
            st <= S_BUSY;
          end
        end
        S_HOLD: begin
          if (dec_err && errc != ERR_MAX) errc <= errc + 1'b1;
          if (exit_q) begin
            if (!cfg[3]) begin
              st <= S_IDLE;
              done <= 1'b1;
            end else begin
              pend_exit <= 1'b1;
              st <= S_BUSY;
            end
          end else if (rel) st <= S_BUSY;
        end
        S_BUSY: begin
          if (waiting) begin
            if (phy_status) waiting <= 1'b0;
          end else if (power_down != goal) begin
            power_down <= next_hop(power_down, goal, cfg[1]);
            waiting <= 1'b1;
          end else begin
            case (phase)
              PH_ENTRY: if (pend_exit) begin
                goal <= exit_goal(tgt, power_down, cfg[4], cfg[5]);
                phase <= PH_EXIT;
                pend_exit <= 1'b0;
              end else begin
                link_state <= tgt;
                done <= 1'b1;
                st <= S_IDLE;
              end
              PH_EXIT: begin
                link_state <= U0;
                done <= 1'b1;
                if (power_down != P0) begin
                  goal <= P0;
                  phase <= PH_TAIL;
                end else st <= S_IDLE;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !phy_status) |=> $stable(power_down));

  // R3
  p2p3_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && !cfg_q[1] && power_down[1])
      |=> (power_down == $past(power_down) || power_down == P0));

  // R5
  hold_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |=> $stable(power_down));

  // R2
  entry_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && link_state != U0) |-> (power_down != P0));

  // R7
  cancel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && exit_q && !cfg_q[3])
      |=> (done && power_down == P0 && link_state == U0));
endmodule

// File: tb/test_pipe_pwr_seq.sv
`timescale 1ns/1ps
module test_pipe_pwr_seq;
  logic       clk = 1'b0, rst_n = 1'b0, link_req_vld = 1'b0;
  logic [1:0] link_req = 2'd0;
  logic [8:0] ctl = 9'd0;
  logic       rx_elec_idle = 1'b1, rx_valid = 1'b0, dec_err = 1'b0, phy_status = 1'b0;
  logic [1:0] power_down, link_state;
  logic       done;

  pipe_pwr_seq i_pipe_pwr_seq (
    .clk(clk), .rst_n(rst_n), .link_req_vld(link_req_vld), .link_req(link_req),
    .ctl(ctl), .rx_elec_idle(rx_elec_idle), .rx_valid(rx_valid), .dec_err(dec_err),
    .phy_status(phy_status), .power_down(power_down), .link_state(link_state), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [1:0] hop_log [0:15];
  logic [1:0] exp_hops [0:15];
  int nh = 0, ne = 0, done_cnt = 0, exp_dn = 0, ack_cnt = 0, viol = 0;
  logic [1:0] done_pd = 2'd0, exp_done_pd = 2'd0, prev_pd = 2'd0, m_pd = 2'd0, m_ls = 2'd0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pd = 2'd0; ack_cnt = 0; phy_status = 1'b0;
    end else begin
      phy_status = 1'b0;
      if (power_down != prev_pd) begin
        if (ack_cnt != 0) viol++;
        if (nh < 16) hop_log[nh] = power_down;
        nh++;
        prev_pd = power_down;
        ack_cnt = 1 + int'($urandom % 3);
      end else if (ack_cnt != 0) begin
        ack_cnt--;
        if (ack_cnt == 0) phy_status = 1'b1;
      end
      if (done) begin
        done_cnt++;
        done_pd = power_down;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_txn();
    nh = 0; ne = 0; done_cnt = 0; exp_dn = 0;
  endtask

  task automatic push(input logic [1:0] p);
    exp_hops[ne] = p;
    ne++;
  endtask

  task automatic add_path(input logic [1:0] a, input logic [1:0] b, input logic direct);
    if (a != b) begin
      if (((a == 2'd2 && b == 2'd3) || (a == 2'd3 && b == 2'd2)) && !direct) push(2'd0);
      push(b);
    end
  endtask

  task automatic m_entry(input logic [1:0] t, input logic [8:0] c);
    logic [1:0] g;
    g = (t == 2'd1) ? 2'd1 : (t == 2'd2) ? (c[0] ? 2'd3 : 2'd2) : 2'd3;
    add_path(m_pd, g, c[1]);
    m_pd = g; m_ls = t; exp_done_pd = g; exp_dn = 1;
  endtask

  task automatic m_exit(input logic [8:0] c);
    logic [1:0] h;
    h = (m_ls == 2'd3 && c[5]) ? 2'd2 : (c[4] ? m_pd : 2'd0);
    add_path(m_pd, h, c[1]);
    exp_done_pd = h;
    add_path(h, 2'd0, c[1]);
    m_pd = 2'd0; m_ls = 2'd0; exp_dn = 1;
  endtask

  task automatic request(input logic [1:0] r);
    link_req = r; link_req_vld = 1'b1;
    @(negedge clk);
    link_req_vld = 1'b0;
  endtask

  task automatic finish_txn(input string tag);
    tick(40);
    chk({tag, " R3 hop count"}, nh, ne);
    for (int k = 0; k < ne && k < nh && k < 16; k++) chk({tag, " R3 hop value"}, hop_log[k], exp_hops[k]);
    chk({tag, " done count"}, done_cnt, exp_dn);
    if (exp_dn != 0) chk({tag, " PowerDown at done"}, done_pd, exp_done_pd);
    chk({tag, " link state"}, link_state, m_ls);
    chk({tag, " final PowerDown"}, power_down, m_pd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [8:0] c;
    logic [1:0] t;
    void'($urandom(32'h5EED_1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset PowerDown", power_down, 0);
    chk("R1 reset link state", link_state, 0);
    chk("R1 reset done", done, 0);

    // R5: hold until idle and not valid
    ctl = 9'b000_000_100; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); m_entry(2'd1, ctl); request(2'd1);
    tick(20); chk("R5 held while rx_valid", nh, 0);
    rx_valid = 1'b0; tick(10); chk("R5 held while not idle", nh, 0);
    rx_elec_idle = 1'b1;
    finish_txn("R5 release");
    ctl = 9'd0; begin_txn(); m_exit(ctl); request(2'd0); finish_txn("R9 exit to P0");

    // R6: error count threshold
    ctl = {3'd2, 6'b000100}; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); m_entry(2'd2, ctl); request(2'd2);
    dec_err = 1'b1; tick(15); dec_err = 1'b0; tick(5);
    chk("R6 held below count", nh, 0);
    dec_err = 1'b1; tick(1); dec_err = 1'b0;
    finish_txn("R6 count reached");
    ctl = 9'd0; begin_txn(); m_exit(ctl); request(2'd0); finish_txn("R9 exit");

    // R6: rx_valid falling releases early
    ctl = {3'd3, 6'b000100}; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); m_entry(2'd3, ctl); request(2'd3);
    dec_err = 1'b1; tick(5); dec_err = 1'b0; tick(5);
    chk("R6 held before rx_valid falls", nh, 0);
    rx_valid = 1'b0;
    finish_txn("R6 rx_valid fell");
    ctl = 9'd0; begin_txn(); m_exit(ctl); request(2'd0); finish_txn("R9 exit from U3");

    // R7: cancel during hold
    ctl = 9'b000_000_100; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); request(2'd1); tick(5); request(2'd0);
    exp_dn = 1; exp_done_pd = 2'd0;
    finish_txn("R7 cancel");

    // R7: cancel coinciding with count release
    ctl = {3'd1, 6'b000100}; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); request(2'd2);
    dec_err = 1'b1; tick(8); dec_err = 1'b0; request(2'd0);
    exp_dn = 1; exp_done_pd = 2'd0;
    finish_txn("R7 cancel same cycle as release");

    // R8: forced request then exit
    ctl = 9'b000_001_100; rx_valid = 1'b1; rx_elec_idle = 1'b0;
    begin_txn(); m_entry(2'd2, ctl); m_exit(ctl); request(2'd2); tick(5); request(2'd0);
    finish_txn("R8 forced request");
    ctl = 9'b000_111_100;
    begin_txn(); m_entry(2'd3, ctl); m_exit(ctl); request(2'd3); tick(5); request(2'd0);
    finish_txn("R8/R11 forced request via P2");
    rx_valid = 1'b0; rx_elec_idle = 1'b1;

    for (int i = 0; i < 120; i++) begin
      if ($urandom % 6 == 0) begin
        t = (m_ls == 2'd0) ? 2'd0 : 2'(1 + $urandom % 3);
        begin_txn(); request(t);
        finish_txn("R13 illegal request");
      end else begin
        c = 9'($urandom) & 9'h1FB;
        ctl = c;
        begin_txn();
        if (m_ls == 2'd0) begin
          t = 2'(1 + $urandom % 3);
          m_entry(t, c); request(t);
          tick(1); ctl = 9'($urandom); request(2'($urandom));
          finish_txn("R2/R12/R13 entry");
        end else begin
          m_exit(c); request(2'd0);
          tick(1); ctl = 9'($urandom); request(2'($urandom));
          finish_txn("R9/R10/R11/R12 exit");
        end
      end
    end

    chk("R4 changes before acknowledge", viol, 0);
    summary();
    $finish;
  end
endmodule